// File: doc/BRIEF.md
# Machine Cycle Sequencer with DMA

This block sequences the machine cycles of a small 8-bit processor core. Every machine cycle is a fixed run of clocks and has one kind: reset, initialise, fetch, execute, DMA-in, DMA-out or interrupt. At the end of each cycle the sequencer picks the next kind. It bases the choice on the pending DMA and interrupt requests, the interrupt-enable flag and an accepted control mode. The control mode is one of load, reset, pause or run.

The sequencer owns the registers that the cycle kinds themselves modify. These are the program-counter selector, the data-pointer selector, the saved-context byte, the interrupt-enable flag and the DMA address pointer. Instruction decode and the arithmetic unit live elsewhere. A single `idle_op` input reports whether the current instruction is the idle opcode. A neighbouring memory interface uses the DMA strobes and the address pointer to move one byte per DMA cycle.

Top module: `cyc_seq`

## Requirements
- R1: Every machine cycle lasts CYC_LEN clocks (default 8). `cyc_last` is high on the final clock of each cycle and low on all other clocks.
- R2: `cyc_kind` encodes reset=0, init=1, fetch=2, execute=3, DMA-in=4, DMA-out=5, interrupt=6. `state_code` is 0 for fetch, 1 for execute, reset and init, 2 for either DMA kind, and 3 for interrupt.
- R3: After an execute cycle the next cycle is chosen in this order: DMA-in if `dma_in_req`, else DMA-out if `dma_out_req`, else interrupt if `ie` and `irq_req` are both high. Otherwise it is execute again when `idle_op` is high or the mode is load, and fetch in all other cases. A fetch cycle is always followed by execute.
- R4: After a DMA cycle the same priority applies. With no request left, the next cycle is execute in load mode and fetch otherwise.
- R5: On the last clock of a DMA-in cycle `dma_wr` pulses, and on the last clock of a DMA-out cycle `dma_rd` pulses. Both present `r0` as the address. `r0` then increases by one.
- R6: At the end of an interrupt cycle `t_reg` becomes {x_reg, p_reg}, `x_reg` becomes 2, `p_reg` becomes 1 and `ie` clears. The next cycle is DMA-in, then DMA-out, by request; otherwise it is fetch.
- R7: A reset cycle sets `ie` and repeats while the mode is reset. Leaving reset for run or load passes through an init cycle, which clears `x_reg`, `p_reg` and `r0`. After init in load mode the next cycle is execute.
- R8: In pause mode, `cyc_last`, the cycle kind, `r0` and all registers hold. Leaving pause for run starts a fetch cycle with no init.
- R9: A request for run mode while in load mode is ignored, and the accepted mode stays load.
- R10: `mode_i` passes through two synchronising flops. A new mode is taken into `mode_act` only at a cycle boundary or while paused. `mode_act` encodes load=0, reset=1, pause=2, run=3, and `mode_i` uses the same encoding.
- R11: While `rst_n` is low the sequencer is in a reset cycle with mode reset and `ie` set. `p_reg`, `x_reg`, `t_reg` and `r0` are 0.
- R12: An interrupt request is ignored while `ie` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested control mode (load=0, reset=1, pause=2, run=3) |
| dma_in_req | input | 1 | DMA-in request |
| dma_out_req | input | 1 | DMA-out request |
| irq_req | input | 1 | Interrupt request |
| idle_op | input | 1 | Current instruction is the idle opcode |
| state_code | output | 2 | External state code |
| cyc_kind | output | 3 | Current machine-cycle kind |
| cyc_last | output | 1 | Final clock of the current cycle |
| mode_act | output | 2 | Accepted control mode |
| dma_wr | output | 1 | Write DMA byte to memory at r0 |
| dma_rd | output | 1 | Read memory at r0 for DMA output |
| r0 | output | ADDR_W | DMA address pointer |
| p_reg | output | 4 | Program-counter selector |
| x_reg | output | 4 | Data-pointer selector |
| t_reg | output | 8 | Saved context {X,P} |
| ie | output | 1 | Interrupt enable |

## Verification
The hardest situation to reach is an interrupt taken while the two selectors already hold nonzero values. The interrupt path sets them to 2 and 1, but leaves `ie` clear. The only way to set `ie` again is a reset cycle, and a normal exit from reset runs init, which clears the selectors. The stimulus therefore goes from a reset cycle straight into pause and then into run. This re-arms `ie` while keeping the selectors at 2 and 1, so a second interrupt must save 0x21 into `t_reg`. Mode requests are always driven early in a cycle, so the two-flop delay has settled before the boundary where the bench expects them to take effect.

// File: rtl/cyc_seq.sv
module cyc_seq #(
  parameter int CYC_LEN = 8,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              dma_in_req,
  input  logic              dma_out_req,
  input  logic              irq_req,
  input  logic              idle_op,
  output logic [1:0]        state_code,
  output logic [2:0]        cyc_kind,
  output logic              cyc_last,
  output logic [1:0]        mode_act,
  output logic              dma_wr,
  output logic              dma_rd,
  output logic [ADDR_W-1:0] r0,
  output logic [3:0]        p_reg,
  output logic [3:0]        x_reg,
  output logic [7:0]        t_reg,
  output logic              ie
);
  localparam int CW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);
  localparam logic [1:0] M_LOAD = 2'd0, M_RST = 2'd1, M_PAUSE = 2'd2, M_RUN = 2'd3;

  typedef enum logic [2:0] {
    K_RST = 3'd0, K_INIT = 3'd1, K_FETCH = 3'd2, K_EXEC = 3'd3,
    K_DMAI = 3'd4, K_DMAO = 3'd5, K_INT = 3'd6
  } kind_t;

  kind_t kind, kind_n, nxt, req_nxt;
  logic [CW-1:0] cnt;
  logic [1:0] ms1, ms2, mode_q, mode_n;

  wire paused  = (mode_q == M_PAUSE);
  wire is_load = (mode_q == M_LOAD);

  assign cyc_last = !paused && (cnt == LAST);
  assign cyc_kind = kind;
  assign mode_act = mode_q;
  assign dma_wr   = cyc_last && (kind == K_DMAI);
  assign dma_rd   = cyc_last && (kind == K_DMAO);

  always_comb begin
    case (kind)
      K_FETCH:        state_code = 2'd0;
      K_DMAI, K_DMAO: state_code = 2'd2;
      K_INT:          state_code = 2'd3;
      default:        state_code = 2'd1;
    endcase
  end

  always_comb begin
    req_nxt = dma_in_req ? K_DMAI : dma_out_req ? K_DMAO : (ie && irq_req) ? K_INT : K_FETCH;
    case (kind)
      K_FETCH:        nxt = K_EXEC;
      K_EXEC:         nxt = (req_nxt == K_FETCH && (idle_op || is_load)) ? K_EXEC : req_nxt;
      K_DMAI, K_DMAO: nxt = (req_nxt == K_FETCH && is_load) ? K_EXEC : req_nxt;
      K_INT:          nxt = dma_in_req ? K_DMAI : dma_out_req ? K_DMAO : K_FETCH;
      K_INIT:         nxt = dma_in_req ? K_DMAI : dma_out_req ? K_DMAO : (is_load ? K_EXEC : K_FETCH);
      default:        nxt = K_RST;
    endcase
  end

  always_comb begin
    mode_n = mode_q;
    kind_n = kind;
    if (paused) begin
      case (ms2)
        M_RUN:   begin mode_n = M_RUN;  kind_n = K_FETCH; end
        M_RST:   begin mode_n = M_RST;  kind_n = K_RST;   end
        M_LOAD:  begin mode_n = M_LOAD; kind_n = K_EXEC;  end
        default: ;
      endcase
    end else if (cyc_last) begin
      case (ms2)
        M_RST:   begin mode_n = M_RST; kind_n = K_RST; end
        M_PAUSE: mode_n = M_PAUSE;
        M_LOAD: begin
          mode_n = M_LOAD;
          kind_n = (mode_q == M_RST) ? K_INIT : nxt;
        end
        default: begin
          if (mode_q == M_RST) begin
            mode_n = M_RUN; kind_n = K_INIT;
          end else begin
            mode_n = mode_q; kind_n = nxt;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1    <= M_RST;
      ms2    <= M_RST;
      mode_q <= M_RST;
      kind   <= K_RST;
      cnt    <= '0;
      ie     <= 1'b1;
      p_reg  <= '0;
      x_reg  <= '0;
      t_reg  <= '0;
      r0     <= '0;
    end else begin
      ms1    <= mode_i;
      ms2    <= ms1;
      mode_q <= mode_n;
      kind   <= kind_n;
      if (paused || cyc_last) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
      if (cyc_last) begin
        case (kind)
          K_RST:  ie <= 1'b1;
          K_INIT: begin x_reg <= '0; p_reg <= '0; r0 <= '0; end
          K_DMAI, K_DMAO: r0 <= r0 + 1'b1;
          K_INT: begin
            t_reg <= {x_reg, p_reg};
            x_reg <= 4'd2;
            p_reg <= 4'd1;
            ie    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_last && !paused) |=> $stable(kind));
  // R5
  dma_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_wr, dma_rd}));
  // R5
  r0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr || dma_rd) |=> (r0 == $past(r0) + 1'b1));
  // R6
  int_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_last && kind == K_INT) |=> (!ie && p_reg == 4'd1 && x_reg == 4'd2));
  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && ms2 == M_PAUSE) |=> ($stable(r0) && $stable(kind) && !cyc_last));
  // R9
  no_load_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOAD) |=> (mode_q != M_RUN));
endmodule

// File: tb/sim_cyc_seq.sv
module sim_cyc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic dma_in_req = 1'b0, dma_out_req = 1'b0, irq_req = 1'b0, idle_op = 1'b0;
  logic [1:0] state_code, mode_act;
  logic [2:0] cyc_kind;
  logic cyc_last, dma_wr, dma_rd, ie;
  logic [15:0] r0;
  logic [3:0] p_reg, x_reg;
  logic [7:0] t_reg;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cyc_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .irq_req(irq_req), .idle_op(idle_op),
    .state_code(state_code), .cyc_kind(cyc_kind), .cyc_last(cyc_last),
    .mode_act(mode_act), .dma_wr(dma_wr), .dma_rd(dma_rd), .r0(r0),
    .p_reg(p_reg), .x_reg(x_reg), .t_reg(t_reg), .ie(ie)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic to_boundary();
    @(negedge clk);
    while (!cyc_last) @(negedge clk);
  endtask

  task automatic next_cycle();
    to_boundary();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R11 kind", cyc_kind, 0);
    chk("R11 mode", mode_act, 1);
    chk("R11 ie", ie, 1);
    chk("R11 r0", r0, 0);
    chk("R2 reset code", state_code, 1);
    rst_n = 1'b1;
    next_cycle();
    chk("R7 reset repeats", cyc_kind, 0);
    mode_i = 2'd3;
    next_cycle();
    chk("R7 init after reset", cyc_kind, 1);
    chk("R2 init code", state_code, 1);
    n = 0;
    @(negedge clk);
    while (!cyc_last) begin n++; @(negedge clk); end
    chk("R1 cycle length", n + 2, 8);
    @(negedge clk);
    chk("R2 fetch kind", cyc_kind, 2);
    chk("R2 fetch code", state_code, 0);
    next_cycle();
    chk("R3 fetch then exec", cyc_kind, 3);
    next_cycle();
    chk("R3 exec then fetch", cyc_kind, 2);
    next_cycle();
    idle_op = 1'b1;
    next_cycle();
    chk("R3 idle stays exec", cyc_kind, 3);
    next_cycle();
    chk("R3 idle stays exec again", cyc_kind, 3);
    idle_op = 1'b0; dma_in_req = 1'b1; dma_out_req = 1'b1; irq_req = 1'b1;
    next_cycle();
    chk("R3 dma-in first", cyc_kind, 4);
    chk("R2 dma code", state_code, 2);
    to_boundary();
    chk("R5 dma_wr", dma_wr, 1);
    chk("R5 dma_rd quiet", dma_rd, 0);
    @(negedge clk);
    chk("R5 r0 step", r0, 1);
    chk("R4 dma-in repeats", cyc_kind, 4);
    dma_in_req = 1'b0;
    next_cycle();
    chk("R4 dma-out next", cyc_kind, 5);
    dma_out_req = 1'b0;
    to_boundary();
    chk("R5 dma_rd", dma_rd, 1);
    @(negedge clk);
    chk("R5 r0 after out", r0, 3);
    chk("R4 interrupt after dma", cyc_kind, 6);
    chk("R2 int code", state_code, 3);
    next_cycle();
    chk("R6 fetch after int", cyc_kind, 2);
    chk("R6 x", x_reg, 2);
    chk("R6 p", p_reg, 1);
    chk("R6 ie", ie, 0);
    chk("R6 t", t_reg, 0);
    next_cycle();
    next_cycle();
    chk("R12 irq ignored", cyc_kind, 2);
    mode_i = 2'd1;
    next_cycle();
    chk("R7 reset entry", cyc_kind, 0);
    mode_i = 2'd2;
    next_cycle();
    chk("R8 paused mode", mode_act, 2);
    chk("R7 reset sets ie", ie, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cyc_last || cyc_kind != 3'd0 || r0 != 16'd3) begin
        chk("R8 hold", {cyc_last, cyc_kind, r0}, {1'b0, 3'd0, 16'd3});
      end
    end
    chk("R8 r0 held", r0, 3);
    mode_i = 2'd3;
    repeat (4) @(negedge clk);
    chk("R8 resume fetch", cyc_kind, 2);
    chk("R8 resume mode", mode_act, 3);
    chk("R8 x kept", x_reg, 2);
    next_cycle();
    chk("R3 exec", cyc_kind, 3);
    next_cycle();
    chk("R3 interrupt taken", cyc_kind, 6);
    dma_out_req = 1'b1; irq_req = 1'b0;
    next_cycle();
    chk("R6 dma after int", cyc_kind, 5);
    chk("R6 t saved", t_reg, 8'h21);
    dma_out_req = 1'b0;
    next_cycle();
    chk("R4 fetch after dma", cyc_kind, 2);
    chk("R5 r0 count", r0, 4);
    mode_i = 2'd2;
    repeat (4) @(negedge clk);
    chk("R10 mode waits for boundary", mode_act, 3);
    to_boundary();
    @(negedge clk);
    chk("R10 mode at boundary", mode_act, 2);
    chk("R8 kind held in pause", cyc_kind, 2);
    mode_i = 2'd1;
    repeat (4) @(negedge clk);
    chk("R7 pause to reset", cyc_kind, 0);
    mode_i = 2'd0;
    next_cycle();
    chk("R7 init into load", cyc_kind, 1);
    chk("R10 load accepted", mode_act, 0);
    next_cycle();
    chk("R7 exec after init", cyc_kind, 3);
    chk("R7 r0 cleared", r0, 0);
    chk("R7 x cleared", x_reg, 0);
    chk("R7 p cleared", p_reg, 0);
    mode_i = 2'd3;
    next_cycle();
    next_cycle();
    chk("R9 run ignored", mode_act, 0);
    chk("R9 still exec", cyc_kind, 3);
    dma_in_req = 1'b1;
    next_cycle();
    chk("R4 load dma", cyc_kind, 4);
    dma_in_req = 1'b0;
    next_cycle();
    chk("R4 load back to exec", cyc_kind, 3);
    chk("R5 r0 load", r0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule